// File: doc/BRIEF.md
# Gradient Edge Thinning Stage

This block is the thinning step of an edge detector. It consumes a raster-ordered stream of gradient samples. Each sample holds a 10-bit magnitude and a 2-bit quantized direction. It produces one 8-bit binary pixel per input sample. A sample survives as an edge (value 255) only when it is a ridge along its own gradient direction and it is strictly stronger than a programmable threshold. Every other sample becomes 0, so the edges that remain are one pixel wide.

Three row stores of up to `MAX_W` samples hold the rows above, at and below the row being judged. The upstream stage fills the lower store. When a row has been loaded and an earlier row is waiting, the block stops accepting input and sweeps that earlier row out at one pixel per cycle. The stores then rotate. After the last row of a frame, one more sweep runs with an empty row below. The stores are then cleared for the next frame.

Frame width, height and the threshold are configuration inputs, held steady during a frame, with 1 <= width <= `MAX_W`. The downstream side always accepts output.

Top module: `nms_thin_stage`

## Requirements
- R1: While reset is active and right after it, `out_valid` is 0, `out_pix` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 while a row is being swept out, and a sample is taken only on a clock edge where `in_valid` and `in_ready` are both 1. Right after the last sample of the second row is taken, `in_ready` is 0.
- R3: A frame of W x H samples yields exactly W x H output pixels in raster order. Each sweep is a run of W consecutive valid cycles, or 2W for the final two rows. `out_pix` is 0 whenever `out_valid` is 0.
- R4: Direction code 0 compares the sample with its left and right neighbours in the same row.
- R5: Direction code 2 compares the sample with the samples directly above and below it.
- R6: Direction code 1 compares with the upper-right and lower-left neighbours. Direction code 3 compares with the upper-left and lower-right neighbours.
- R7: The output is 255 when the magnitude is >= both selected neighbours and > the threshold, and 0 otherwise. A tie with a neighbour keeps the pixel. A magnitude equal to the threshold drops it.
- R8: A neighbour position outside the frame (beyond any edge) reads as magnitude 0.
- R9: A 1 x 1 frame, a single-column frame and a single-row frame are processed correctly. Each new frame starts from cleared stores.
- R10: When H > 1, no output appears while the first row is loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 16 | Frame width in samples (1..MAX_W) |
| cfg_height | input | 16 | Frame height in rows (>= 1) |
| cfg_thresh | input | 10 | Edge threshold; the magnitude must exceed it |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_mag | input | 10 | Gradient magnitude |
| in_dir | input | 2 | Quantized gradient direction code |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 8 | Edge pixel, 255 or 0 |

## Verification
The hardest case to reach from the ports is a decision where the two neighbours in the gradient direction come from different row stores, and one of them lies past the frame edge. This happens for diagonal directions on the first or last row and at the first or last column. The bench reaches it by building small frames where the centre sample is surrounded by chosen values on the axis of its direction and a background value off that axis. It also sends ramp frames of mixed directions, where every border pixel runs through the zero-padding path. Single-row, single-column and 1 x 1 frames exercise the immediate final sweep and the clear between frames.

// File: rtl/nms_pkg.sv
package nms_pkg;
    localparam int MAG_W = 10;
    localparam int DIR_W = 2;
    localparam int PIX_W = 8;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [DIR_W-1:0] dir;
        logic [MAG_W-1:0] mag;
    } grad_t;

    typedef enum logic [DIR_W-1:0] {
        DIR_HORZ    = 2'd0,
        DIR_DIAG_UP = 2'd1,
        DIR_VERT    = 2'd2,
        DIR_DIAG_DN = 2'd3
    } dir_e;

    typedef enum logic {
        PH_LOAD,
        PH_EMIT
    } phase_e;

    // 3x3 magnitude window around the sample under test
    typedef struct packed {
        logic [MAG_W-1:0] nw, n, ne;
        logic [MAG_W-1:0] w, c, e;
        logic [MAG_W-1:0] sw, s, se;
    } win_t;
endpackage

// File: rtl/nms_row_bank.sv
module nms_row_bank
    import nms_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_col,
    input  grad_t            wr_pix,
    input  logic             rotate,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_col,
    input  logic             left_ok,
    input  logic             right_ok,
    output win_t             win,
    output logic [DIR_W-1:0] ctr_dir
);
    typedef grad_t [MAX_W-1:0] row_t;

    typedef struct packed {
        row_t top;
        row_t mid;
        row_t bot;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [MAG_W-1:0] mag_of(row_t r, logic [IDX_W-1:0] i, logic ok);
        return ok ? r[i].mag : '0;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.bot[wr_col] = wr_pix;
        end
        if (rotate) begin
            bank_d.top = bank_q.mid;
            bank_d.mid = bank_d.bot;
            bank_d.bot = '0;
        end
        if (clear) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    logic [IDX_W-1:0] col_l, col_r;
    assign col_l = rd_col - IDX_W'(1);
    assign col_r = rd_col + IDX_W'(1);

    always_comb begin
        win.nw = mag_of(bank_q.top, col_l, left_ok);
        win.n  = mag_of(bank_q.top, rd_col, 1'b1);
        win.ne = mag_of(bank_q.top, col_r, right_ok);
        win.w  = mag_of(bank_q.mid, col_l, left_ok);
        win.c  = mag_of(bank_q.mid, rd_col, 1'b1);
        win.e  = mag_of(bank_q.mid, col_r, right_ok);
        win.sw = mag_of(bank_q.bot, col_l, left_ok);
        win.s  = mag_of(bank_q.bot, rd_col, 1'b1);
        win.se = mag_of(bank_q.bot, col_r, right_ok);
    end

    assign ctr_dir = bank_q.mid[rd_col].dir;
endmodule

// File: rtl/nms_peak_test.sv
module nms_peak_test
    import nms_pkg::*;
(
    input  win_t             win,
    input  logic [DIR_W-1:0] dir,
    input  logic [MAG_W-1:0] thresh,
    output logic [PIX_W-1:0] edge_pix
);
    logic [MAG_W-1:0] side_a, side_b;

    always_comb begin
        unique case (dir_e'(dir))
            DIR_HORZ:    begin side_a = win.w;  side_b = win.e;  end
            DIR_DIAG_UP: begin side_a = win.ne; side_b = win.sw; end
            DIR_VERT:    begin side_a = win.n;  side_b = win.s;  end
            default:     begin side_a = win.nw; side_b = win.se; end
        endcase
        if (win.c >= side_a && win.c >= side_b && win.c > thresh) begin
            edge_pix = '1;
        end else begin
            edge_pix = '0;
        end
    end
endmodule

// File: rtl/nms_thin_stage.sv
module nms_thin_stage
    import nms_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      cfg_width,
    input  logic [CNT_W-1:0]      cfg_height,
    input  logic [MAG_W-1:0]      cfg_thresh,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [MAG_W-1:0]      in_mag,
    input  logic [DIR_W-1:0]      in_dir,
    output logic                  out_valid,
    output logic [PIX_W-1:0]      out_pix
);
    typedef struct packed {
        phase_e           phase;
        logic             last;
        logic [CNT_W-1:0] col;
        logic [CNT_W-1:0] rows;
        logic             ovalid;
        logic [PIX_W-1:0] opix;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             wr_en, rotate, clear;
    logic             row_end, left_ok, right_ok;
    win_t             win;
    logic [DIR_W-1:0] ctr_dir;
    logic [PIX_W-1:0] edge_pix;
    grad_t            in_pix;

    assign in_pix   = '{dir: in_dir, mag: in_mag};
    assign row_end  = (ctl_q.col == cfg_width - CNT_W'(1));
    assign left_ok  = (ctl_q.col != '0);
    assign right_ok = ((ctl_q.col + CNT_W'(1)) < cfg_width);

    nms_row_bank #(.MAX_W(MAX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_col   (ctl_q.col[IDX_W-1:0]),
        .wr_pix   (in_pix),
        .rotate   (rotate),
        .clear    (clear),
        .rd_col   (ctl_q.col[IDX_W-1:0]),
        .left_ok  (left_ok),
        .right_ok (right_ok),
        .win      (win),
        .ctr_dir  (ctr_dir)
    );

    nms_peak_test u_peak (
        .win      (win),
        .dir      (ctr_dir),
        .thresh   (cfg_thresh),
        .edge_pix (edge_pix)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ovalid = 1'b0;
        ctl_d.opix   = '0;
        wr_en        = 1'b0;
        rotate       = 1'b0;
        clear        = 1'b0;
        if (ctl_q.phase == PH_LOAD) begin
            if (in_valid) begin
                wr_en = 1'b1;
                if (row_end) begin
                    ctl_d.col  = '0;
                    ctl_d.rows = ctl_q.rows + CNT_W'(1);
                    if (ctl_q.rows == '0) begin
                        // first row: move it to the middle store, nothing to judge yet
                        rotate = 1'b1;
                        if (cfg_height == CNT_W'(1)) begin
                            ctl_d.phase = PH_EMIT;
                            ctl_d.last  = 1'b1;
                        end
                    end else begin
                        ctl_d.phase = PH_EMIT;
                    end
                end else begin
                    ctl_d.col = ctl_q.col + CNT_W'(1);
                end
            end
        end else begin
            ctl_d.ovalid = 1'b1;
            ctl_d.opix   = edge_pix;
            if (row_end) begin
                ctl_d.col = '0;
                rotate    = 1'b1;
                if (ctl_q.last) begin
                    clear       = 1'b1;
                    ctl_d.rows  = '0;
                    ctl_d.last  = 1'b0;
                    ctl_d.phase = PH_LOAD;
                end else if (ctl_q.rows == cfg_height) begin
                    ctl_d.last = 1'b1;
                end else begin
                    ctl_d.phase = PH_LOAD;
                end
            end else begin
                ctl_d.col = ctl_q.col + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_LOAD, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = (ctl_q.phase == PH_LOAD);
    assign out_valid = ctl_q.ovalid;
    assign out_pix   = ctl_q.opix;
endmodule

// File: rtl/nms_thin_stage_chk.sv
module nms_thin_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_width,
    input logic        in_ready,
    input logic        out_valid,
    input logic [7:0]  out_pix
);
    logic [16:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (out_valid) begin
            run_q <= run_q + 17'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R2: a sweep starts only after a cycle with input closed
    p_sweep_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !$past(in_ready));

    // R7: pixels are binary
    p_binary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pix == 8'd0 || out_pix == 8'd255));

    // R3: idle output is zero
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_pix == 8'd0);

    // R3: sweep run length is one or two rows
    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (run_q == {1'b0, cfg_width} || run_q == {cfg_width, 1'b0}));
endmodule

bind nms_thin_stage nms_thin_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_width (cfg_width),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/test_nms_thin_stage.sv
module test_nms_thin_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_width = 16'd3;
    logic [15:0] cfg_height = 16'd3;
    logic [9:0]  cfg_thresh = 10'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_mag = '0;
    logic [1:0]  in_dir = '0;
    logic        out_valid;
    logic [7:0]  out_pix;

    always #2.5 clk = ~clk;

    nms_thin_stage i_nms_thin_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cfg_thresh (cfg_thresh),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_mag     (in_mag),
        .in_dir     (in_dir),
        .out_valid  (out_valid),
        .out_pix    (out_pix)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int img_m [0:7][0:7];
    int img_d [0:7][0:7];
    int got   [0:63];
    int got_n = 0;

    // collect outputs away from the active edge
    always @(negedge clk) begin
        if (out_valid && got_n < 64) begin
            got[got_n] = int'(out_pix);
            got_n = got_n + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nb(int r, int c, int w, int h);
        if (r < 0 || c < 0 || r >= h || c >= w) return 0;
        return img_m[r][c];
    endfunction

    // reference from the requirements (R4..R8)
    function automatic int model(int r, int c, int w, int h, int thr);
        int a, b, m;
        m = img_m[r][c];
        case (img_d[r][c])
            0: begin a = nb(r, c-1, w, h);   b = nb(r, c+1, w, h);   end
            1: begin a = nb(r-1, c+1, w, h); b = nb(r+1, c-1, w, h); end
            2: begin a = nb(r-1, c, w, h);   b = nb(r+1, c, w, h);   end
            default: begin a = nb(r-1, c-1, w, h); b = nb(r+1, c+1, w, h); end
        endcase
        return (m >= a && m >= b && m > thr) ? 255 : 0;
    endfunction

    task automatic send(int m, int d);
        in_valid = 1'b1;
        in_mag   = 10'(m);
        in_dir   = 2'(d);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(int w, int h, int thr, bit gaps, bit flow);
        int bad;
        int first_bad;
        cfg_width  = 16'(w);
        cfg_height = 16'(h);
        cfg_thresh = 10'(thr);
        got_n = 0;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                send(img_m[r][c], img_d[r][c]);
                if (gaps && ((r + c) % 3 == 0)) @(negedge clk);
                if (flow && r == 1 && c == w - 1)
                    chk("R2 in_ready after second row", int'(in_ready), 0);
            end
            if (flow && r == 0 && h > 1)
                chk("R10 no output during first row", got_n, 0);
        end
        repeat (2 * w + 6) @(negedge clk);
        chk("R3 output count", got_n, w * h);
        bad = 0;
        first_bad = -1;
        for (int i = 0; i < w * h && i < got_n; i++) begin
            if (got[i] != model(i / w, i % w, w, h, thr)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            chk("R7/R8 frame pixel", got[first_bad],
                model(first_bad / w, first_bad % w, w, h, thr));
        else
            chk("R7 R8 frame mismatches", bad, 0);
    endtask

    function automatic string dir_tag(int d);
        case (d)
            0: return "R4 horizontal";
            2: return "R5 vertical";
            default: return "R6 diagonal";
        endcase
    endfunction

    // {dir, centre, side a, side b, background, threshold, expected}
    localparam logic [59:0] VEC [9] = '{
        {2'd0, 10'd100,  10'd50,   10'd60,  10'd500, 10'd10,  8'd255},
        {2'd0, 10'd100,  10'd101,  10'd60,  10'd1,   10'd10,  8'd0},
        {2'd2, 10'd100,  10'd100,  10'd100, 10'd1,   10'd10,  8'd255},
        {2'd2, 10'd100,  10'd20,   10'd200, 10'd1,   10'd10,  8'd0},
        {2'd1, 10'd300,  10'd299,  10'd0,   10'd900, 10'd299, 8'd255},
        {2'd1, 10'd300,  10'd10,   10'd10,  10'd1,   10'd300, 8'd0},
        {2'd3, 10'd1023, 10'd1023, 10'd5,   10'd1,   10'd0,   8'd255},
        {2'd3, 10'd50,   10'd60,   10'd0,   10'd1,   10'd0,   8'd0},
        {2'd2, 10'd40,   10'd5,    10'd5,   10'd700, 10'd40,  8'd0}
    };

    task automatic main_flow();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_pix after reset", int'(out_pix), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);

        // table of 3x3 cases, centre judged against chosen neighbours
        for (int k = 0; k < 9; k++) begin
            int d, a, b, bg;
            d  = int'(VEC[k][59:58]);
            a  = int'(VEC[k][47:38]);
            b  = int'(VEC[k][37:28]);
            bg = int'(VEC[k][27:18]);
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++) begin
                    img_m[r][c] = bg;
                    img_d[r][c] = 0;
                end
            img_m[1][1] = int'(VEC[k][57:48]);
            img_d[1][1] = d;
            case (d)
                0: begin img_m[1][0] = a; img_m[1][2] = b; end
                1: begin img_m[0][2] = a; img_m[2][0] = b; end
                2: begin img_m[0][1] = a; img_m[2][1] = b; end
                default: begin img_m[0][0] = a; img_m[2][2] = b; end
            endcase
            run_frame(3, 3, int'(VEC[k][17:8]), 1'b0, 1'b0);
            chk(dir_tag(d), got[4], int'(VEC[k][7:0]));
        end

        // ramp frame, mixed directions, input gaps, flow checks
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 6; c++) begin
                img_m[r][c] = (r * 37 + c * 91 + r * c * 13) % 1024;
                img_d[r][c] = (r + c) % 4;
            end
        run_frame(6, 5, 100, 1'b1, 1'b1);

        // R9 / R8: 1x1 frames, all neighbours outside read as zero
        img_m[0][0] = 5; img_d[0][0] = 3;
        run_frame(1, 1, 0, 1'b0, 1'b0);
        chk("R9 1x1 above threshold", got[0], 255);
        run_frame(1, 1, 5, 1'b0, 1'b0);
        chk("R9 1x1 equal threshold", got[0], 0);

        // R9: single column, vertical direction
        img_m[0][0] = 10; img_m[1][0] = 30; img_m[2][0] = 20; img_m[3][0] = 40;
        for (int r = 0; r < 4; r++) img_d[r][0] = 2;
        run_frame(1, 4, 0, 1'b0, 1'b0);
        chk("R9 column bottom pixel R8", got[3], 255);

        // R9: single row, horizontal direction
        for (int c = 0; c < 8; c++) begin
            img_m[0][c] = (c % 2 == 0) ? 200 : 80;
            img_d[0][c] = 0;
        end
        run_frame(8, 1, 50, 1'b0, 1'b0);
        chk("R8 row left edge", got[0], 255);
        chk("R4 row trough", got[1], 0);
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule